// File: doc/BRIEF.md
# Paged Frame Cache Controller

This controller places a small on-chip RAM of fixed-size page frames in front of a larger, slow backing store. A requester presents a store byte address and receives the on-chip RAM address that holds that byte. If the page is already resident, the answer comes back one cycle after the request is taken. Otherwise the controller claims a frame and asks an external transfer engine to fill it. It then answers once that engine signals completion.

The controller tracks the span of bytes written in each frame. It records this as the lowest and highest written offset within the page. When a frame must be freed, only that span is handed to the transfer engine, and a frame that was never written is freed with no transfer. Frames are claimed in rotating order. As soon as the last free frame has been filled, the oldest frame is scheduled for eviction, so a free frame is ready before the next miss. The frame the requester used most recently is never the one chosen. A separate counter of allocated store pages raises a flag once half the store is in use.

Top module: `pgc_ctrl`

## Requirements
- R1: After reset, busy, lk_ack, fill_req, wb_req, mem_full and half_full are all low.
- R2: A lookup whose page is resident is answered with lk_ack high for exactly one cycle, in the cycle after it is taken. lk_phys equals the frame index times 64 plus address bits [5:0].
- R3: On a miss, fill_req rises with fill_page = address bits [15:6] and fill_frame = the claimed frame. These hold steady until fill_done. lk_ack with the RAM address follows in the cycle after fill_done.
- R4: Frames are claimed in the order 0, 1, … 19 and then wrap to 0. mem_full rises when the claim pointer wraps and stays high.
- R5: A filled frame starts clean (first offset 0x3F, last offset 0x00). A clean frame chosen for eviction is freed with no write-back request.
- R6: Each byte write (wr_en, wr_frame, wr_off) widens its frame's span, so the span runs from the lowest written offset to the highest. wb_first and wb_last report this span.
- R7: When a fill leaves every frame valid, the victim is the frame at the claim pointer (the oldest). If that frame is the one most recently answered on lk_ack, the next frame is chosen instead, and the pointer moves past the skipped frame.
- R8: A victim is written back (wb_req with wb_page, wb_frame, wb_first, wb_last) only when its first offset is not above its last offset. On wb_done the frame becomes free.
- R9: While a fill or write-back is outstanding, busy is high and no lookup is answered.
- R10: fill_req and wb_req are never high together.
- R11: A byte write to the victim frame in the same cycle as the fill_done that triggers the eviction is included in the reported span.
- R12: half_full rises once store_alloc has been pulsed 512 times (half of the 1024 store pages) and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request, held until lk_ack |
| lk_addr | input | 16 | Store byte address to look up |
| lk_ack | output | 1 | One-cycle answer strobe |
| lk_phys | output | 11 | On-chip RAM byte address of the answer |
| busy | output | 1 | Fill or write-back outstanding |
| wr_en | input | 1 | Byte write into the on-chip RAM |
| wr_frame | input | 5 | Frame of the byte write |
| wr_off | input | 6 | Offset of the byte write |
| fill_req | output | 1 | Fill request to the transfer engine |
| fill_page | output | 10 | Store page number to read |
| fill_frame | output | 5 | Frame to fill |
| fill_done | input | 1 | Fill completed |
| wb_req | output | 1 | Write-back request to the transfer engine |
| wb_page | output | 10 | Store page number to write |
| wb_frame | output | 5 | Frame to write from |
| wb_first | output | 6 | First offset of the dirty span |
| wb_last | output | 6 | Last offset of the dirty span |
| wb_done | input | 1 | Write-back completed |
| store_alloc | input | 1 | One store page allocated |
| mem_full | output | 1 | Claim pointer has wrapped |
| half_full | output | 1 | Half of the store pages allocated |

## Verification
Span tracking and eviction launch can act in the same cycle. A byte write may land on the very frame that a completing fill selects as the victim. The bench provokes this by driving a write to the victim frame at offset 0x30 in the cycle it raises fill_done. It judges the result by requiring that wb_last report 0x30, not the older span end of 0x07. A write lost in the launch cycle would show up as a stale span on the write-back request.

// File: rtl/pgc_pkg.sv
// Shared types for the paged frame cache controller.
package pgc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_WB   = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/pgc_frame_table.sv
// Per-frame bookkeeping: tag, valid bit and written byte span.
// Looks up a tag against all frames in parallel and exposes the
// post-write span of one selected frame so that a write in the
// current cycle is already visible to the reader.
// Assumes fill and invalidate never name the same frame in one cycle.
module pgc_frame_table #(
    parameter int N_FR  = 20,
    parameter int TAG_W = 10,
    parameter int OFF_W = 6,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] look_tag,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             inv_we,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_frame,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [OFF_W-1:0] rd_first,
    output logic [OFF_W-1:0] rd_last,
    output logic [N_FR-1:0]  valid_o
);
    localparam logic [OFF_W-1:0] CLEAN_FIRST = '1;
    localparam logic [OFF_W-1:0] CLEAN_LAST  = '0;

    logic [N_FR-1:0][TAG_W-1:0] tag_all;
    logic [N_FR-1:0][OFF_W-1:0] first_nx_all;
    logic [N_FR-1:0][OFF_W-1:0] last_nx_all;
    logic [N_FR-1:0]            match;

    for (genvar g = 0; g < N_FR; g++) begin : g_frame
        logic [TAG_W-1:0] tag_r;
        logic             vld_r;
        logic [OFF_W-1:0] first_r, last_r;
        logic [OFF_W-1:0] first_nx, last_nx;
        logic             wr_here;

        // Widen the span with a write aimed at this frame.
        always_comb begin
            wr_here  = wr_en && (wr_frame == IDX_W'(g));
            first_nx = (wr_here && (wr_off < first_r)) ? wr_off : first_r;
            last_nx  = (wr_here && (wr_off > last_r))  ? wr_off : last_r;
        end

        // Frame state: fill loads tag and marks clean, else track writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r   <= '0;
                vld_r   <= 1'b0;
                first_r <= CLEAN_FIRST;
                last_r  <= CLEAN_LAST;
            end else if (fill_we && (fill_idx == IDX_W'(g))) begin
                tag_r   <= fill_tag;
                vld_r   <= 1'b1;
                first_r <= CLEAN_FIRST;
                last_r  <= CLEAN_LAST;
            end else begin
                if (inv_we && (inv_idx == IDX_W'(g))) vld_r <= 1'b0;
                first_r <= first_nx;
                last_r  <= last_nx;
            end
        end

        assign tag_all[g]      = tag_r;
        assign first_nx_all[g] = first_nx;
        assign last_nx_all[g]  = last_nx;
        assign valid_o[g]      = vld_r;
        assign match[g]        = vld_r && (tag_r == look_tag);
    end

    // Encode the matching frame, lowest index wins.
    always_comb begin
        hit_idx = '0;
        for (int i = N_FR - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
        hit = |match;
    end

    assign rd_tag   = tag_all[rd_idx];
    assign rd_first = first_nx_all[rd_idx];
    assign rd_last  = last_nx_all[rd_idx];
endmodule

// File: rtl/pgc_alloc.sv
// Rotating frame claim pointer with wrap flag, plus a saturating
// count of allocated store pages with a half-store flag.
// Assumes at most one pointer advance per cycle.
module pgc_alloc #(
    parameter int N_FR  = 20,
    parameter int IDX_W = 5,
    parameter int PG_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             store_alloc,
    output logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] ptr_next,
    output logic             mem_full,
    output logic             half_full
);
    localparam logic [PG_W:0] PG_TOTAL = (PG_W + 1)'(1) << PG_W;
    localparam logic [PG_W:0] PG_HALF  = (PG_W + 1)'(1) << (PG_W - 1);
    localparam logic [IDX_W-1:0] LAST_FR = IDX_W'(N_FR - 1);

    logic [PG_W:0] pg_cnt;

    assign ptr_next  = (ptr == LAST_FR) ? '0 : ptr + 1'b1;
    assign half_full = (pg_cnt >= PG_HALF);

    // Advance the claim pointer and note the first wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            mem_full <= 1'b0;
        end else if (adv) begin
            ptr <= ptr_next;
            if (ptr == LAST_FR) mem_full <= 1'b1;
        end
    end

    // Count allocated store pages up to the store size.
    always_ff @(posedge clk) begin
        if (!rst_n) pg_cnt <= '0;
        else if (store_alloc && (pg_cnt != PG_TOTAL)) pg_cnt <= pg_cnt + 1'b1;
    end
endmodule

// File: rtl/pgc_ctrl.sv
// Top of the paged frame cache controller. Answers lookups from the
// frame table, claims frames on a miss and drives a fill handshake,
// then schedules eviction of the oldest frame (skipping the frame in
// use) once the pool is full, writing back only its dirty span.
// Assumes lk_req is held until lk_ack and that the transfer engine
// answers each request with a single done pulse.
module pgc_ctrl #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 6,
    parameter int N_FR   = 20,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int IDX_W  = $clog2(N_FR),
    localparam int PHYS_W = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ack,
    output logic [PHYS_W-1:0] lk_phys,
    output logic              busy,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_frame,
    input  logic [OFF_W-1:0]  wr_off,
    output logic              fill_req,
    output logic [TAG_W-1:0]  fill_page,
    output logic [IDX_W-1:0]  fill_frame,
    input  logic              fill_done,
    output logic              wb_req,
    output logic [TAG_W-1:0]  wb_page,
    output logic [IDX_W-1:0]  wb_frame,
    output logic [OFF_W-1:0]  wb_first,
    output logic [OFF_W-1:0]  wb_last,
    input  logic              wb_done,
    input  logic              store_alloc,
    output logic              mem_full,
    output logic              half_full
);
    import pgc_pkg::*;

    ctl_state_e       state_q;
    logic [TAG_W-1:0] pend_tag_q;
    logic [OFF_W-1:0] pend_off_q;
    logic [IDX_W-1:0] fill_frame_q;
    logic [IDX_W-1:0] cur_q;

    logic [TAG_W-1:0] look_tag;
    logic [OFF_W-1:0] look_off;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [N_FR-1:0]  valid;
    logic [IDX_W-1:0] ptr, ptr_next;
    logic             accept, claim, fill_fin, pool_full, skip_cur, adv;
    logic [IDX_W-1:0] victim;
    logic [TAG_W-1:0] v_tag;
    logic [OFF_W-1:0] v_first, v_last;
    logic             v_dirty, inv_we;
    logic [IDX_W-1:0] inv_idx;
    logic [N_FR-1:0]  fill_bit;

    assign look_tag = lk_addr[ADDR_W-1:OFF_W];
    assign look_off = lk_addr[OFF_W-1:0];

    // Decide acceptance, claims and the eviction victim.
    always_comb begin
        accept    = (state_q == ST_IDLE) && lk_req && !lk_ack;
        claim     = accept && !hit;
        fill_fin  = (state_q == ST_FILL) && fill_done;
        fill_bit  = N_FR'(1) << fill_frame_q;
        pool_full = &(valid | fill_bit);
        skip_cur  = (ptr == cur_q);
        victim    = skip_cur ? ptr_next : ptr;
        adv       = claim || (fill_fin && pool_full && skip_cur);
        v_dirty   = (v_first <= v_last);
        inv_we    = (fill_fin && pool_full && !v_dirty) ||
                    ((state_q == ST_WB) && wb_done);
        inv_idx   = (state_q == ST_WB) ? wb_frame : victim;
    end

    pgc_frame_table #(
        .N_FR(N_FR), .TAG_W(TAG_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_tag (look_tag),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .fill_we  (fill_fin),
        .fill_idx (fill_frame_q),
        .fill_tag (pend_tag_q),
        .inv_we   (inv_we),
        .inv_idx  (inv_idx),
        .wr_en    (wr_en),
        .wr_frame (wr_frame),
        .wr_off   (wr_off),
        .rd_idx   (victim),
        .rd_tag   (v_tag),
        .rd_first (v_first),
        .rd_last  (v_last),
        .valid_o  (valid)
    );

    pgc_alloc #(
        .N_FR(N_FR), .IDX_W(IDX_W), .PG_W(TAG_W)
    ) u_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .store_alloc (store_alloc),
        .ptr         (ptr),
        .ptr_next    (ptr_next),
        .mem_full    (mem_full),
        .half_full   (half_full)
    );

    // Sequence lookups, fills and write-backs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            lk_ack       <= 1'b0;
            lk_phys      <= '0;
            pend_tag_q   <= '0;
            pend_off_q   <= '0;
            fill_frame_q <= '0;
            cur_q        <= '0;
            wb_page      <= '0;
            wb_frame     <= '0;
            wb_first     <= '0;
            wb_last      <= '0;
        end else begin
            lk_ack <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept && hit) begin
                        lk_ack  <= 1'b1;
                        lk_phys <= {hit_idx, look_off};
                        cur_q   <= hit_idx;
                    end else if (claim) begin
                        pend_tag_q   <= look_tag;
                        pend_off_q   <= look_off;
                        fill_frame_q <= ptr;
                        state_q      <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (fill_done) begin
                        lk_ack  <= 1'b1;
                        lk_phys <= {fill_frame_q, pend_off_q};
                        cur_q   <= fill_frame_q;
                        if (pool_full && v_dirty) begin
                            state_q  <= ST_WB;
                            wb_page  <= v_tag;
                            wb_frame <= victim;
                            wb_first <= v_first;
                            wb_last  <= v_last;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_WB: begin
                    if (wb_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign fill_req   = (state_q == ST_FILL);
    assign fill_page  = pend_tag_q;
    assign fill_frame = fill_frame_q;
    assign wb_req     = (state_q == ST_WB);
endmodule

// File: rtl/pgc_ctrl_chk.sv
// Protocol checker for pgc_ctrl, attached by bind.
module pgc_ctrl_chk #(
    parameter int TAG_W = 10,
    parameter int OFF_W = 6,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_ack,
    input logic             fill_req,
    input logic [TAG_W-1:0] fill_page,
    input logic [IDX_W-1:0] fill_frame,
    input logic             fill_done,
    input logic             wb_req,
    input logic [OFF_W-1:0] wb_first,
    input logic [OFF_W-1:0] wb_last,
    input logic             mem_full,
    input logic             half_full
);
    a_r10_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_req && wb_req));

    a_r3_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_done) |=> (fill_req && $stable(fill_page) && $stable(fill_frame)));

    a_r9_no_ack_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && $past(wb_req)) |-> !lk_ack);

    a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ack |=> !lk_ack);

    a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mem_full |=> mem_full);

    a_r12_half_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        half_full |=> half_full);

    a_r8_span_order: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (wb_first <= wb_last));
endmodule

bind pgc_ctrl pgc_ctrl_chk #(.TAG_W(TAG_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_ack     (lk_ack),
    .fill_req   (fill_req),
    .fill_page  (fill_page),
    .fill_frame (fill_frame),
    .fill_done  (fill_done),
    .wb_req     (wb_req),
    .wb_first   (wb_first),
    .wb_last    (wb_last),
    .mem_full   (mem_full),
    .half_full  (half_full)
);

// File: tb/pgc_ctrl_tb.sv
// Self-checking bench for pgc_ctrl: a vector table of lookups, then
// directed tests for eviction, spans, stalls and the flags.
module pgc_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [15:0] lk_addr = '0;
    logic        lk_ack;
    logic [10:0] lk_phys;
    logic        busy;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_frame = '0;
    logic [5:0]  wr_off = '0;
    logic        fill_req;
    logic [9:0]  fill_page;
    logic [4:0]  fill_frame;
    logic        fill_done = 1'b0;
    logic        wb_req;
    logic [9:0]  wb_page;
    logic [4:0]  wb_frame;
    logic [5:0]  wb_first, wb_last;
    logic        wb_done = 1'b0;
    logic        store_alloc = 1'b0;
    logic        mem_full, half_full;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pgc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_ack(lk_ack), .lk_phys(lk_phys), .busy(busy),
        .wr_en(wr_en), .wr_frame(wr_frame), .wr_off(wr_off),
        .fill_req(fill_req), .fill_page(fill_page), .fill_frame(fill_frame),
        .fill_done(fill_done), .wb_req(wb_req), .wb_page(wb_page),
        .wb_frame(wb_frame), .wb_first(wb_first), .wb_last(wb_last),
        .wb_done(wb_done), .store_alloc(store_alloc),
        .mem_full(mem_full), .half_full(half_full)
    );

    // {address, expect miss, expected RAM address}
    localparam logic [27:0] VEC [8] = '{
        {16'h0000, 1'b1, 11'd0},
        {16'h0005, 1'b0, 11'd5},
        {16'h0140, 1'b1, 11'd64},
        {16'h0152, 1'b0, 11'd82},
        {16'h003F, 1'b0, 11'd63},
        {16'hFFC1, 1'b1, 11'd129},
        {16'h0141, 1'b0, 11'd65},
        {16'hFFFF, 1'b0, 11'd191}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_lookup(input logic [15:0] a, input bit race,
                             input logic [4:0] rf, input logic [5:0] ro,
                             output bit missed, output logic [10:0] ph,
                             output logic [9:0] fpage, output logic [4:0] fframe);
        @(negedge clk);
        lk_addr = a;
        lk_req  = 1'b1;
        missed  = 1'b0;
        ph = '0; fpage = '0; fframe = '0;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            fill_done = 1'b0;
            wr_en     = 1'b0;
            if (lk_ack) begin
                ph = lk_phys;
                break;
            end
            if (fill_req && !missed) begin
                missed    = 1'b1;
                fpage     = fill_page;
                fframe    = fill_frame;
                fill_done = 1'b1;
                if (race) begin
                    wr_en = 1'b1; wr_frame = rf; wr_off = ro;
                end
            end
        end
        lk_req = 1'b0;
    endtask

    task automatic wr_byte(input logic [4:0] f, input logic [5:0] o);
        @(negedge clk);
        wr_en = 1'b1; wr_frame = f; wr_off = o;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic serve_wb(input string req, input int ef, input int ep,
                            input int e_first, input int e_last);
        bit seen = 1'b0;
        for (int n = 0; n < 50; n++) begin
            if (wb_req) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(seen, req, int'(seen), 1);
        chk(!fill_req, "R10", int'(fill_req), 0);
        chk(wb_frame == ef, req, wb_frame, ef);
        chk(wb_page == ep, req, wb_page, ep);
        chk(wb_first == e_first, req, wb_first, e_first);
        chk(wb_last == e_last, req, wb_last, e_last);
        wb_done = 1'b1;
        @(negedge clk);
        wb_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit          m;
        logic [10:0] ph;
        logic [9:0]  fp;
        logic [4:0]  ff;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !lk_ack && !fill_req && !wb_req, "R1", int'(busy), 0);
        chk(!mem_full && !half_full, "R1", int'(mem_full), 0);

        // R2 / R3 / R4: vector walk
        for (int i = 0; i < 8; i++) begin
            do_lookup(VEC[i][27:12], 1'b0, '0, '0, m, ph, fp, ff);
            chk(m == VEC[i][11], VEC[i][11] ? "R3" : "R2", int'(m), int'(VEC[i][11]));
            chk(ph == VEC[i][10:0], "R2", ph, VEC[i][10:0]);
            if (VEC[i][11]) begin
                chk(fp == VEC[i][27:18], "R3", fp, VEC[i][27:18]);
                chk(ff == VEC[i][10:6], "R4", ff, VEC[i][10:6]);
            end
        end

        // R6 spans: frame 1 gets 3..20, frame 2 gets 7..7
        wr_byte(5'd1, 6'd10);
        wr_byte(5'd1, 6'd3);
        wr_byte(5'd1, 6'd20);
        wr_byte(5'd2, 6'd7);

        // R4 fill frames 3..18 in order
        for (int k = 0; k < 16; k++) begin
            do_lookup(16'((16'h10 + k) << 6), 1'b0, '0, '0, m, ph, fp, ff);
            chk(m && ff == 5'(3 + k), "R4", ff, 3 + k);
        end
        chk(!mem_full, "R4", int'(mem_full), 0);

        // make frame 0 the one in use
        do_lookup(16'h0000, 1'b0, '0, '0, m, ph, fp, ff);
        chk(!m && ph == 11'd0, "R2", ph, 0);

        // R7: last free frame claimed; oldest (0) in use, so frame 1 evicted
        do_lookup(16'hC000, 1'b0, '0, '0, m, ph, fp, ff);
        chk(m && ff == 5'd19, "R4", ff, 19);
        chk(mem_full, "R4", int'(mem_full), 1);
        chk(busy, "R9", int'(busy), 1);

        // R9: lookup held during write-back is not answered
        lk_addr = 16'h0400;
        lk_req  = 1'b1;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk(!lk_ack && busy, "R9", int'(lk_ack), 0);
        end
        lk_req = 1'b0;
        serve_wb("R7", 1, 5, 3, 20);

        // R11: write to victim frame 2 in the fill_done cycle
        do_lookup(16'h0140, 1'b1, 5'd2, 6'h30, m, ph, fp, ff);
        chk(m && ff == 5'd1, "R8", ff, 1);
        chk(ph == 11'd64, "R3", ph, 64);
        serve_wb("R11", 2, 10'h3FF, 7, 6'h30);

        // R5: victim frame 3 never written, freed without write-back
        do_lookup(16'h8000, 1'b0, '0, '0, m, ph, fp, ff);
        chk(m && ff == 5'd2, "R4", ff, 2);
        chk(!wb_req && !busy, "R5", int'(wb_req), 0);
        do_lookup(16'h0400, 1'b0, '0, '0, m, ph, fp, ff);
        chk(m && ff == 5'd3, "R5", ff, 3);

        // R7: skipped frame 0 is still resident
        do_lookup(16'h003F, 1'b0, '0, '0, m, ph, fp, ff);
        chk(!m && ph == 11'd63, "R7", ph, 63);

        // R12 half-store flag
        for (int n = 0; n < 511; n++) begin
            @(negedge clk);
            store_alloc = 1'b1;
        end
        @(negedge clk);
        store_alloc = 1'b0;
        chk(!half_full, "R12", int'(half_full), 0);
        store_alloc = 1'b1;
        @(negedge clk);
        store_alloc = 1'b0;
        chk(half_full, "R12", int'(half_full), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule